// File: doc/BRIEF.md
# Write-Path ECC Poison Matcher

This block sits on the write path of a DRAM controller, after the address has been split into DRAM coordinates (row, column, bank, bank group, rank, logical rank and channel) and after the check bits of each ECC lane have been computed. Two programmed match words describe one target location. When matching is switched on and a write lands on exactly that location, the block corrupts the stored check bits of every armed lane by XORing in that lane's flip pattern. Pattern 0x1 makes a single-bit error that the read path can correct. Pattern 0x3 makes a double-bit error that it cannot correct.

Reads, writes that miss any field, and all traffic while matching is off pass through untouched. Every beat goes through one output register, so a poisoned beat has the same latency as a clean one. The data half of each beat is never altered. Only the check bits can change.

Top module: `wr_poison_matcher`

## Requirements
- R1: While reset is asserted, out_valid_o, out_write_o and out_hit_o are 0 and out_data_o and out_check_o are all zeros, whatever the inputs do.
- R2: Each beat appears at the outputs exactly one clock after it is presented: out_valid_o equals the previous in_valid_i, out_write_o equals the previous in_valid_i AND in_write_i, and out_data_o equals the previous in_data_i bit for bit.
- R3: Match word A holds the row in bits 17:0, the column in bits 27:18, the bank in bits 29:28 and the bank group in bits 31:30. A write whose row, column, bank or group differs from its field is not poisoned.
- R4: Match word B holds the rank in bits 1:0, the logical rank in bits 4:2 and the channel in bit 5. A write whose rank, logical rank or channel differs from its field is not poisoned.
- R5: Poisoning requires both the enable bit (word B bit 8) and the mode flag (word B bit 6) to be 1. If either is 0, no beat is poisoned.
- R6: A beat with in_write_i = 0 (a read) is never poisoned.
- R7: A lane is armed only when its 8-bit control field in lane_ctrl_i (lane n in bits 8n+7:8n) equals 0xFF. An unarmed lane's check bits pass unchanged, even on a hit.
- R8: On a hit, each armed lane n outputs its check bits XOR its flip pattern (lane_flip_i bits 8n+7:8n), applied to the low bits of that lane. Pattern 0x1 changes exactly one bit and pattern 0x3 changes exactly two bits. Lanes act independently.
- R9: out_hit_o is 1 exactly for output beats that were valid writes matching every field while enabled, regardless of lane arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_a_i | input | 32 | Match word A: row, column, bank, bank group |
| match_b_i | input | 32 | Match word B: rank, logical rank, channel, mode flag, enable |
| lane_ctrl_i | input | 16 | Per-lane control bytes (0xFF arms the lane) |
| lane_flip_i | input | 16 | Per-lane flip patterns |
| in_valid_i | input | 1 | Input beat valid |
| in_write_i | input | 1 | Beat is a write (1) or a read (0) |
| in_row_i | input | 18 | Row coordinate |
| in_col_i | input | 10 | Column coordinate |
| in_bank_i | input | 2 | Bank coordinate |
| in_grp_i | input | 2 | Bank group coordinate |
| in_rank_i | input | 2 | Rank coordinate |
| in_lrank_i | input | 3 | Logical rank coordinate |
| in_ch_i | input | 1 | Channel coordinate |
| in_data_i | input | 128 | Data of all lanes |
| in_check_i | input | 16 | Check bits of all lanes |
| out_valid_o | output | 1 | Output beat valid |
| out_write_o | output | 1 | Output beat is a write |
| out_data_o | output | 128 | Data, unchanged |
| out_check_o | output | 16 | Check bits, possibly poisoned |
| out_hit_o | output | 1 | Output beat was a poison hit |

## Verification
The bench targets writes that miss by a single least significant bit in each of the seven fields, one at a time. A comparator with a swapped or shifted field slice would poison these near-misses, or would fail to poison the exact hit. It clears the mode flag and the enable bit separately, so a design that tests only one of them would poison while disabled. It arms one lane with 0xFE and the other with 0xFF, which exposes a design that decodes arming from a single bit or applies one lane's pattern to both. It also checks that pattern 0x1 changes one bit and 0x3 changes two, which catches a mask placed at the wrong end of the check field.

// File: rtl/wpm_pkg.sv
`timescale 1ns/1ps
package wpm_pkg;
   localparam int          CTRL_W   = 8;
   localparam logic [7:0]  ARM_CODE = 8'hFF;
   localparam int          WORD_W   = 32;
   localparam int          MODE_BIT = 6;
   localparam int          EN_BIT   = 8;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_PASS   = 2'd1,
      ACT_POISON = 2'd2
   } beat_act_e;
endpackage

// File: rtl/coord_cmp.sv
`timescale 1ns/1ps
module coord_cmp #(
   parameter int ROW_W   = 18,
   parameter int COL_W   = 10,
   parameter int BANK_W  = 2,
   parameter int GRP_W   = 2,
   parameter int RANK_W  = 2,
   parameter int LRANK_W = 3,
   parameter int CH_W    = 1
) (
   input  logic [wpm_pkg::WORD_W-1:0] word_a_i,
   input  logic [wpm_pkg::WORD_W-1:0] word_b_i,
   input  logic [ROW_W-1:0]           row_i,
   input  logic [COL_W-1:0]           col_i,
   input  logic [BANK_W-1:0]          bank_i,
   input  logic [GRP_W-1:0]           grp_i,
   input  logic [RANK_W-1:0]          rank_i,
   input  logic [LRANK_W-1:0]         lrank_i,
   input  logic [CH_W-1:0]            ch_i,
   output logic                       match_o
);
   localparam int ROW_LSB   = 0;
   localparam int COL_LSB   = ROW_LSB + ROW_W;
   localparam int BANK_LSB  = COL_LSB + COL_W;
   localparam int GRP_LSB   = BANK_LSB + BANK_W;
   localparam int A_USED    = GRP_LSB + GRP_W;
   localparam int RANK_LSB  = 0;
   localparam int LRANK_LSB = RANK_LSB + RANK_W;
   localparam int CH_LSB    = LRANK_LSB + LRANK_W;
   localparam int B_USED    = CH_LSB + CH_W;
   localparam int N_FIELDS  = 7;

   if (A_USED > wpm_pkg::WORD_W) begin : g_bad_a
      $error("coord_cmp: word A fields exceed the word width");
   end
   if (B_USED > wpm_pkg::MODE_BIT) begin : g_bad_b
      $error("coord_cmp: word B fields collide with the mode flag");
   end

   logic [N_FIELDS-1:0] field_eq;

   assign field_eq[0] = (row_i   == word_a_i[ROW_LSB   +: ROW_W]);
   assign field_eq[1] = (col_i   == word_a_i[COL_LSB   +: COL_W]);
   assign field_eq[2] = (bank_i  == word_a_i[BANK_LSB  +: BANK_W]);
   assign field_eq[3] = (grp_i   == word_a_i[GRP_LSB   +: GRP_W]);
   assign field_eq[4] = (rank_i  == word_b_i[RANK_LSB  +: RANK_W]);
   assign field_eq[5] = (lrank_i == word_b_i[LRANK_LSB +: LRANK_W]);
   assign field_eq[6] = (ch_i    == word_b_i[CH_LSB    +: CH_W]);

   assign match_o = &field_eq;

   logic unused_words;
   assign unused_words = ^{word_a_i, word_b_i};
endmodule

// File: rtl/lane_poisoner.sv
`timescale 1ns/1ps
module lane_poisoner #(
   parameter int CHK_W  = 8,
   parameter int FLIP_W = 8
) (
   input  logic [wpm_pkg::CTRL_W-1:0] ctrl_i,
   input  logic [FLIP_W-1:0]          pattern_i,
   input  logic                       fire_i,
   input  logic [CHK_W-1:0]           chk_i,
   output logic [CHK_W-1:0]           chk_o
);
   logic             armed;
   logic [CHK_W-1:0] mask;

   if (FLIP_W > CHK_W) begin : g_bad_w
      $error("lane_poisoner: flip pattern wider than check field");
   end else if (FLIP_W == CHK_W) begin : g_full
      assign mask = pattern_i;
   end else begin : g_low
      assign mask = {{(CHK_W - FLIP_W){1'b0}}, pattern_i};
   end

   assign armed = (ctrl_i == wpm_pkg::ARM_CODE);
   assign chk_o = chk_i ^ ((armed && fire_i) ? mask : '0);
endmodule

// File: rtl/wr_poison_matcher.sv
`timescale 1ns/1ps
module wr_poison_matcher #(
   parameter int LANES   = 2,
   parameter int DATA_W  = 64,
   parameter int CHK_W   = 8,
   parameter int FLIP_W  = 8,
   parameter int ROW_W   = 18,
   parameter int COL_W   = 10,
   parameter int BANK_W  = 2,
   parameter int GRP_W   = 2,
   parameter int RANK_W  = 2,
   parameter int LRANK_W = 3,
   parameter int CH_W    = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [wpm_pkg::WORD_W-1:0]         match_a_i,
   input  logic [wpm_pkg::WORD_W-1:0]         match_b_i,
   input  logic [LANES*wpm_pkg::CTRL_W-1:0]   lane_ctrl_i,
   input  logic [LANES*FLIP_W-1:0]            lane_flip_i,
   input  logic                               in_valid_i,
   input  logic                               in_write_i,
   input  logic [ROW_W-1:0]                   in_row_i,
   input  logic [COL_W-1:0]                   in_col_i,
   input  logic [BANK_W-1:0]                  in_bank_i,
   input  logic [GRP_W-1:0]                   in_grp_i,
   input  logic [RANK_W-1:0]                  in_rank_i,
   input  logic [LRANK_W-1:0]                 in_lrank_i,
   input  logic [CH_W-1:0]                    in_ch_i,
   input  logic [LANES*DATA_W-1:0]            in_data_i,
   input  logic [LANES*CHK_W-1:0]             in_check_i,
   output logic                               out_valid_o,
   output logic                               out_write_o,
   output logic [LANES*DATA_W-1:0]            out_data_o,
   output logic [LANES*CHK_W-1:0]             out_check_o,
   output logic                               out_hit_o
);
   import wpm_pkg::*;

   localparam int CTRL_TOT = LANES * CTRL_W;
   localparam int CHK_TOT  = LANES * CHK_W;
   localparam int ROW_LSB  = 0;
   localparam int CH_LSB   = RANK_W + LRANK_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("wr_poison_matcher: LANES must be at least 1");
   end

   logic               coord_hit;
   logic               gate_on;
   logic               fire;
   logic [CHK_TOT-1:0] chk_mod;
   beat_act_e          act_d, act_q;

   coord_cmp #(
      .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .GRP_W(GRP_W),
      .RANK_W(RANK_W), .LRANK_W(LRANK_W), .CH_W(CH_W)
   ) cmp_i (
      .word_a_i (match_a_i),
      .word_b_i (match_b_i),
      .row_i    (in_row_i),
      .col_i    (in_col_i),
      .bank_i   (in_bank_i),
      .grp_i    (in_grp_i),
      .rank_i   (in_rank_i),
      .lrank_i  (in_lrank_i),
      .ch_i     (in_ch_i),
      .match_o  (coord_hit)
   );

   assign gate_on = match_b_i[EN_BIT] & match_b_i[MODE_BIT];
   assign fire    = in_valid_i & in_write_i & gate_on & coord_hit;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_poisoner #(.CHK_W(CHK_W), .FLIP_W(FLIP_W)) pois_i (
         .ctrl_i    (lane_ctrl_i[l*CTRL_W +: CTRL_W]),
         .pattern_i (lane_flip_i[l*FLIP_W +: FLIP_W]),
         .fire_i    (fire),
         .chk_i     (in_check_i[l*CHK_W +: CHK_W]),
         .chk_o     (chk_mod[l*CHK_W +: CHK_W])
      );
   end

   always_comb begin
      if (!in_valid_i)  act_d = ACT_IDLE;
      else if (fire)    act_d = ACT_POISON;
      else              act_d = ACT_PASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_write_o <= 1'b0;
         out_data_o  <= '0;
         out_check_o <= '0;
         act_q       <= ACT_IDLE;
      end else begin
         out_valid_o <= in_valid_i;
         out_write_o <= in_valid_i & in_write_i;
         out_data_o  <= in_data_i;
         out_check_o <= chk_mod;
         act_q       <= act_d;
      end
   end

   assign out_hit_o = (act_q == ACT_POISON);

   logic unused_ctrl;
   assign unused_ctrl = ^{lane_ctrl_i[CTRL_TOT-1:0], 1'b0};

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> out_valid_o); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> (!out_valid_o && !out_hit_o)); // R2
   AST_DATA_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> (out_data_o == $past(in_data_i))); // R2
   AST_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !in_write_i) |=> (!out_hit_o && out_check_o == $past(in_check_i))); // R6
   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !(match_b_i[EN_BIT] && match_b_i[MODE_BIT]))
         |=> (!out_hit_o && out_check_o == $past(in_check_i))); // R5
   AST_ROW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_row_i != match_a_i[ROW_LSB +: ROW_W]) |=> !out_hit_o); // R3
   AST_CH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ch_i != match_b_i[CH_LSB +: CH_W]) |=> !out_hit_o); // R4

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      AST_UNARMED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid_i && lane_ctrl_i[l*CTRL_W +: CTRL_W] != ARM_CODE)
            |=> (out_check_o[l*CHK_W +: CHK_W] == $past(in_check_i[l*CHK_W +: CHK_W]))); // R7
      AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid_i && lane_flip_i[l*FLIP_W +: FLIP_W] == FLIP_W'(1))
            |=> ($countones(out_check_o[l*CHK_W +: CHK_W]
                            ^ $past(in_check_i[l*CHK_W +: CHK_W])) <= 1)); // R8
   end
endmodule

// File: tb/wr_poison_matcher_tb.sv
`timescale 1ns/1ps
module wr_poison_matcher_tb_top;
   localparam int LANES = 2;
   localparam int DW    = 64;
   localparam int CW    = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                  rst_n;
   logic [31:0]           ma, mb;
   logic [LANES*8-1:0]    ctrl, flip;
   logic                  iv, iw;
   logic [17:0]           row;
   logic [9:0]            col;
   logic [1:0]            bank, grp, rank;
   logic [2:0]            lrank;
   logic [0:0]            ch;
   logic [LANES*DW-1:0]   idata;
   logic [LANES*CW-1:0]   ichk;
   logic                  ov, ow, oh;
   logic [LANES*DW-1:0]   odata;
   logic [LANES*CW-1:0]   ochk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   wr_poison_matcher dut_i (
      .clk(clk), .rst_n(rst_n), .match_a_i(ma), .match_b_i(mb),
      .lane_ctrl_i(ctrl), .lane_flip_i(flip), .in_valid_i(iv), .in_write_i(iw),
      .in_row_i(row), .in_col_i(col), .in_bank_i(bank), .in_grp_i(grp),
      .in_rank_i(rank), .in_lrank_i(lrank), .in_ch_i(ch), .in_data_i(idata),
      .in_check_i(ichk), .out_valid_o(ov), .out_write_o(ow), .out_data_o(odata),
      .out_check_o(ochk), .out_hit_o(oh)
   );

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic model_hit();
      return iv && iw && mb[8] && mb[6] &&
             row == ma[17:0] && col == ma[27:18] && bank == ma[29:28] &&
             grp == ma[31:30] && rank == mb[1:0] && lrank == mb[4:2] &&
             ch == mb[5];
   endfunction

   function automatic logic [LANES*CW-1:0] model_chk(logic hit);
      logic [LANES*CW-1:0] r = ichk;
      for (int l = 0; l < LANES; l++)
         if (hit && ctrl[l*8 +: 8] == 8'hFF)
            r[l*CW +: CW] = ichk[l*CW +: CW] ^ flip[l*8 +: 8];
      return r;
   endfunction

   // drive at negedge; outputs are checked 1 ns after the next rising edge
   task automatic beat(string tag);
      logic                e_hit  = model_hit();
      logic [LANES*CW-1:0] e_chk  = model_chk(e_hit);
      logic [LANES*DW-1:0] e_dat  = idata;
      logic                e_v    = iv;
      logic                e_w    = iv & iw;
      logic [LANES*CW-1:0] in_c   = ichk;
      @(posedge clk); #1;
      chk({tag, " R2 valid"}, 128'(ov), 128'(e_v));
      chk({tag, " R2 write"}, 128'(ow), 128'(e_w));
      chk({tag, " R2 data"},  128'(odata), 128'(e_dat));
      chk({tag, " R8 check"}, 128'(ochk), 128'(e_chk));
      chk({tag, " R9 hit"},   128'(oh), 128'(e_hit));
      @(negedge clk);
      if (in_c != ichk) n_fail++;
   endtask

   task automatic aim();
      row = ma[17:0]; col = ma[27:18]; bank = ma[29:28]; grp = ma[31:30];
      rank = mb[1:0]; lrank = mb[4:2]; ch = mb[5];
   endtask

   task automatic new_payload();
      idata = {$urandom, $urandom, $urandom, $urandom};
      ichk  = 16'($urandom);
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n = 1'b0; iv = 1'b1; iw = 1'b1;
      ma = 32'hFFFF_FFFF; mb = 32'h0000_017F;
      ctrl = 16'hFFFF; flip = 16'h0303;
      aim(); new_payload();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset valid", 128'(ov), 128'(0));
      chk("R1 reset write", 128'(ow), 128'(0));
      chk("R1 reset hit",   128'(oh), 128'(0));
      chk("R1 reset data",  128'(odata), 128'(0));
      chk("R1 reset check", 128'(ochk), 128'(0));
      @(negedge clk);
      rst_n = 1'b1;

      // exact hit, lane0 single-bit, lane1 double-bit
      ma = $urandom; mb = (32'($urandom) & 32'h3F) | 32'h140;
      aim(); new_payload(); ctrl = 16'hFFFF; flip = 16'h0301;
      iv = 1; iw = 1;
      beat("R8 hit");
      chk("R8 lane0 single bit", 128'($countones(ochk[7:0] ^ ichk[7:0])), 128'(1));
      chk("R8 lane1 double bit", 128'($countones(ochk[15:8] ^ ichk[15:8])), 128'(2));

      mb[6] = 0; new_payload(); beat("R5 mode clear");
      mb[6] = 1; mb[8] = 0; new_payload(); beat("R5 enable clear");
      mb[8] = 1;
      iw = 0; new_payload(); beat("R6 read"); iw = 1;
      ctrl = 16'hFFFE; new_payload(); beat("R7 lane0 FE");
      chk("R7 lane0 untouched", 128'(ochk[7:0]), 128'(ichk[7:0]));
      ctrl = 16'hFFFF;

      for (int f = 0; f < 7; f++) begin
         aim(); new_payload();
         case (f)
            0: row[0]   = ~row[0];
            1: col[0]   = ~col[0];
            2: bank[0]  = ~bank[0];
            3: grp[0]   = ~grp[0];
            4: rank[0]  = ~rank[0];
            5: lrank[0] = ~lrank[0];
            default: ch[0] = ~ch[0];
         endcase
         beat(f < 4 ? "R3 word A miss" : "R4 word B miss");
         chk(f < 4 ? "R3 no hit" : "R4 no hit", 128'(oh), 128'(0));
      end
      aim();
      iv = 0; new_payload(); beat("R2 idle");
      iv = 1;

      for (int i = 0; i < 400; i++) begin
         ma = $urandom;
         mb = 32'($urandom) & 32'h3F;
         if ($urandom_range(0, 7) != 0) mb[6] = 1;
         if ($urandom_range(0, 7) != 0) mb[8] = 1;
         aim();
         if ($urandom_range(0, 3) == 0) begin
            row = 18'($urandom); col = 10'($urandom);
         end
         if ($urandom_range(0, 5) == 0) ch = ~ch;
         if ($urandom_range(0, 5) == 0) lrank = 3'($urandom);
         ctrl[7:0]  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
         ctrl[15:8] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
         flip[7:0]  = ($urandom_range(0, 1) == 0) ? 8'h01 : 8'h03;
         flip[15:8] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h03;
         iv = ($urandom_range(0, 9) != 0);
         iw = ($urandom_range(0, 4) != 0);
         new_payload();
         beat("R3 R4 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule